// File: doc/BRIEF.md
# Capture-Compare Timer

This block is an up-counting timer with a programmable prescaler, three compare channels that each drive an output pin, and two capture channels that each sample the counter on chosen edges of an external input. A host reaches it through a simple single-cycle register bus: a write is one cycle with `bus_wr` high, and a read is combinational on `bus_addr`. A clock-enable input `tick` supplies the count source, so the timer shares the system clock.

The counter either runs freely and wraps to zero, raising a rollover flag, or restarts from zero after it reaches the first compare value. Compare matches and capture events raise sticky status flags. A software clear of a flag writes a one to its bit. The interrupt output is the OR of all flags that are enabled. A self-clearing software reset bit returns every register to its reset value.

Register word index on `bus_addr`: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare values of channels 1/2/3, 7/8 captured values of channels 1/2, 9 counter (read-only). The counter width is the parameter `CNT_W` (default 32). The bus is always 32 bits wide, and narrower values read back zero-extended.

Top module: `gpt_cc_timer`

## Requirements
- R1: After reset every register reads 0, all three compare pins are 1 and `irq` is 0.
- R2: With control bit 0 set, the counter advances by one on every (P+1)-th cycle in which `tick` is high, where P is the prescaler value. With bit 0 clear, the counter holds its value.
- R3: When the counter advances from all ones it becomes 0 and sets status bit 5 (rollover).
- R4: With control bit 9 set, the counter advances to 0 (not +1) on the step that follows the one in which it equals compare value 1.
- R5: A step that brings the counter to compare value n sets status bit n-1 (bits 0..2). Compare values the counter never reaches set no flag.
- R6: On a match, a compare pin applies the action in its 3-bit mode field: bits 22:20 for channel 1, 25:23 for channel 2, 28:26 for channel 3. The codes are 0 hold, 1 toggle, 2 drive 0, 3 drive 1.
- R7: Mode code 4 drives the pin 0 from the matching step until the next counter step, then back to 1.
- R8: Writing 1 to control bit 29/30/31 applies the stored action of channel 1/2/3 on the next cycle without setting any flag. These bits read back as 0.
- R9: Capture modes sit in control bits 17:16 (channel 1) and 19:18 (channel 2), with codes 0 off, 1 rising, 2 falling, 3 both. An accepted edge latches the counter three clock edges after the input changes. An edge that is not selected leaves the value unchanged.
- R10: An accepted capture sets status bit 3 (channel 1) or 4 (channel 2).
- R11: Writing 1 to a status bit clears it. If a new event for that bit occurs in the same cycle, the bit stays set.
- R12: `irq` is high exactly when some status bit and the same interrupt-enable bit are both 1.
- R13: Writing control bit 15 makes that bit read 1 for one cycle. On the next cycle every register, the counter and the pins return to their reset values, and bit 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-source clock enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cap_in | input | 2 | Capture inputs, asynchronous |
| cmp_out | output | 3 | Compare output pins |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the prescaler and compare values change only while the timer is stopped or between the events they govern. They also assume that `cap_in` holds each level for at least two clocks, so the synchronizer sees every edge. The stimulus reprograms registers only after a software reset or with the counter halted. It drives `tick` randomly at a fixed seed only in the prescaler trials, and keeps capture levels stable for several cycles. Directed sequences place a status clear in the exact cycle of a compare match to exercise the collision rule.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 4;
  localparam int N_CMP  = 3;
  localparam int N_CAP  = 2;
  localparam int N_FLAG = N_CMP + N_CAP + 1;

  localparam logic [ADDR_W-1:0] REG_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] REG_PRE  = 4'd1;
  localparam logic [ADDR_W-1:0] REG_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] REG_IEN  = 4'd3;
  localparam int                REG_CMP0 = 4;
  localparam int                REG_CAP0 = REG_CMP0 + N_CMP;
  localparam logic [ADDR_W-1:0] REG_CNT  = 4'd9;

  // control word bit positions (decoded by the channels)
  localparam int CB_EN      = 0;
  localparam int CB_RESTART = 9;
  localparam int CB_SWR     = 15;
  localparam int CB_CAPM    = 16;
  localparam int CB_CMPM    = 20;
  localparam int CB_FORCE   = 29;
  localparam logic [31:0] CTRL_KEEP = 32'h1FFF_0201;

  typedef enum logic [2:0] {
    OM_HOLD   = 3'd0,
    OM_TOGGLE = 3'd1,
    OM_LOW    = 3'd2,
    OM_HIGH   = 3'd3,
    OM_PULSE  = 3'd4
  } om_e;

  typedef enum logic [1:0] {
    CM_OFF  = 2'd0,
    CM_RISE = 2'd1,
    CM_FALL = 2'd2,
    CM_BOTH = 2'd3
  } cm_e;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [PRE_W-1:0] div,
  output logic             step
);
  logic [PRE_W-1:0] pcnt;
  logic             at_end;

  assign at_end = (pcnt >= div);
  assign step   = run && tick && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pcnt <= '0;
    end else if (run && tick) begin
      pcnt <= at_end ? '0 : pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             restart,
  input  logic [CNT_W-1:0] cmp1,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);
  logic reload;

  assign reload  = restart && (cnt == cmp1);
  assign wrap    = step && (&cnt);
  assign cnt_nxt = !step ? cnt : (reload ? '0 : cnt + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else               cnt <= cnt_nxt;
  end

  a_r2_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> (cnt == $past(cnt)));

  a_r4_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && restart && (cnt == cmp1) && !clr) |=> (cnt == '0));
endmodule

// File: rtl/gpt_cmp_chan.sv
module gpt_cmp_chan
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             frc,
  output logic             hit,
  output logic             pin
);
  logic pend;
  logic act;

  assign hit = step && (cnt_nxt == cmp);
  assign act = hit || frc;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pin  <= 1'b1;
      pend <= 1'b0;
    end else if (act) begin
      pend <= 1'b0;
      case (mode)
        OM_TOGGLE: pin <= ~pin;
        OM_LOW:    pin <= 1'b0;
        OM_HIGH:   pin <= 1'b1;
        OM_PULSE: begin
          pin  <= 1'b0;
          pend <= 1'b1;
        end
        default:   pin <= pin;
      endcase
    end else if (step && pend) begin
      pin  <= 1'b1;
      pend <= 1'b0;
    end
  end

  a_r7_pulse_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && step && !act && !clr) |=> pin);

  a_r6_hold_mode_keeps_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OM_HOLD && !pend && !clr) |=> $stable(pin));
endmodule

// File: rtl/gpt_cap_chan.sv
module gpt_cap_chan
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  cm_e              mode,
  input  logic             pin_in,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic [CNT_W-1:0] value
);
  logic s1, s2, prev;
  logic rise, fall;

  assign rise = s2 && !prev;
  assign fall = !s2 && prev;

  always_comb begin
    case (mode)
      CM_RISE: hit = rise;
      CM_FALL: hit = fall;
      CM_BOTH: hit = rise || fall;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= pin_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) value <= '0;
    else if (hit)      value <= cnt;
  end

  a_r9_latch_counter: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> (value == $past(cnt)));

  a_r9_unselected_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !clr) |=> $stable(value));
endmodule

// File: rtl/gpt_cc_timer.sv
module gpt_cc_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_CAP-1:0]  cap_in,
  output logic [N_CMP-1:0]  cmp_out,
  output logic              irq
);
  logic [31:0]       ctrl_q;
  logic              swr_q;
  logic [PRE_W-1:0]  pre_q;
  logic [N_FLAG-1:0] ien_q;
  logic [N_FLAG-1:0] stat_q;
  logic [CNT_W-1:0]  cmp_q [N_CMP];
  logic [CNT_W-1:0]  cap_val [N_CAP];
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic              step, wrap;
  logic [N_CMP-1:0]  cmp_hit, frc_vec;
  logic [N_CAP-1:0]  cap_hit;
  logic [N_FLAG-1:0] set_vec, w1c;
  logic              wr_ctrl;

  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign w1c     = (bus_wr && bus_addr == REG_STAT) ? bus_wdata[N_FLAG-1:0] : '0;
  assign set_vec = {wrap, cap_hit, cmp_hit};
  assign irq     = |(stat_q & ien_q);

  always_ff @(posedge clk) begin
    if (!rst_n || swr_q) begin
      ctrl_q <= '0;
      swr_q  <= 1'b0;
      pre_q  <= '0;
      ien_q  <= '0;
      stat_q <= '0;
      for (int i = 0; i < N_CMP; i++) cmp_q[i] <= '0;
    end else begin
      swr_q  <= wr_ctrl && bus_wdata[CB_SWR];
      stat_q <= (stat_q & ~w1c) | set_vec;
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (bus_wr && bus_addr == REG_PRE) pre_q <= bus_wdata[PRE_W-1:0];
      if (bus_wr && bus_addr == REG_IEN) ien_q <= bus_wdata[N_FLAG-1:0];
      for (int i = 0; i < N_CMP; i++) begin
        if (bus_wr && bus_addr == ADDR_W'(REG_CMP0 + i)) cmp_q[i] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: bus_rdata = ctrl_q | (32'(swr_q) << CB_SWR);
      REG_PRE:  bus_rdata = 32'(pre_q);
      REG_STAT: bus_rdata = 32'(stat_q);
      REG_IEN:  bus_rdata = 32'(ien_q);
      REG_CNT:  bus_rdata = 32'(cnt);
      default:  bus_rdata = '0;
    endcase
    for (int i = 0; i < N_CMP; i++) begin
      if (bus_addr == ADDR_W'(REG_CMP0 + i)) bus_rdata = 32'(cmp_q[i]);
    end
    for (int j = 0; j < N_CAP; j++) begin
      if (bus_addr == ADDR_W'(REG_CAP0 + j)) bus_rdata = 32'(cap_val[j]);
    end
  end

  gpt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(swr_q), .run(ctrl_q[CB_EN]),
    .tick(tick), .div(pre_q), .step(step)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(swr_q), .step(step),
    .restart(ctrl_q[CB_RESTART]), .cmp1(cmp_q[0]),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    logic [2:0] mode;
    assign mode       = ctrl_q[CB_CMPM + 3*i +: 3];
    assign frc_vec[i] = wr_ctrl && bus_wdata[CB_FORCE + i];
    gpt_cmp_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .clr(swr_q), .step(step), .mode(mode),
      .cnt_nxt(cnt_nxt), .cmp(cmp_q[i]), .frc(frc_vec[i]),
      .hit(cmp_hit[i]), .pin(cmp_out[i])
    );
  end

  for (genvar j = 0; j < N_CAP; j++) begin : g_cap
    cm_e mode;
    assign mode = cm_e'(ctrl_q[CB_CAPM + 2*j +: 2]);
    gpt_cap_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .clr(swr_q), .mode(mode),
      .pin_in(cap_in[j]), .cnt(cnt), .hit(cap_hit[j]), .value(cap_val[j])
    );
  end

  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !swr_q |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !swr_q |=> ((stat_q & $past(stat_q & ~w1c)) == $past(stat_q & ~w1c)));

  a_r13_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    swr_q |=> (!swr_q && stat_q == '0 && ctrl_q == '0 && cnt == '0));
endmodule

// File: tb/gpt_cc_timer_test.sv
module gpt_cc_timer_test;
  localparam int W = 8;
  localparam logic [3:0] A_CTRL = 4'd0, A_PRE = 4'd1, A_STAT = 4'd2, A_IEN = 4'd3;
  localparam logic [3:0] A_CMP1 = 4'd4, A_CMP2 = 4'd5, A_CMP3 = 4'd6;
  localparam logic [3:0] A_CAP1 = 4'd7, A_CAP2 = 4'd8, A_CNT = 4'd9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = A_CNT;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0] cap_in = 2'b00;
  logic [2:0] cmp_out;
  logic irq;
  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  gpt_cc_timer #(.CNT_W(W), .PRE_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .cmp_out(cmp_out), .irq(irq)
  );

  function automatic logic [31:0] cw(bit en, bit rs, logic [2:0] o1, logic [2:0] o2,
                                     logic [2:0] o3, logic [1:0] i1, logic [1:0] i2);
    return {3'b000, o3, o2, o1, i2, i1, 6'b0, rs, 8'b0, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_CNT; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = A_CNT;
  endtask

  task automatic wait_cnt(input logic [31:0] v, input string req);
    logic [31:0] c;
    for (int k = 0; k < 2000; k++) begin
      rd(A_CNT, c);
      if (c == v) return;
      @(negedge clk);
    end
    chk(req, c, v);
  endtask

  task automatic soft_reset();
    wr(A_CTRL, 32'h0000_8000);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] r, v, v2;
    logic [2:0] ep;
    logic [31:0] cmpv [3];
    logic [2:0] md [3];
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), r);
      chk("R1 register reset", r, 0);
    end
    chk("R1 pins idle", 32'(cmp_out), 32'h7);
    chk("R1 irq idle", 32'(irq), 0);

    // R2 random prescaler trials
    for (int t = 0; t < 5; t++) begin
      int div, nt;
      soft_reset();
      div = (t == 0) ? 0 : int'($urandom % 6);
      wr(A_PRE, 32'(div));
      wr(A_CTRL, cw(1, 0, 0, 0, 0, 0, 0));
      nt = 0;
      for (int k = 0; k < 40; k++) begin
        tick = 1'($urandom % 2);
        if (tick) nt++;
        @(negedge clk);
      end
      tick = 1'b0;
      rd(A_CNT, r);
      chk("R2 prescaled count", r, 32'(nt / (div + 1)));
      wr(A_CTRL, 0);
      tick = 1'b1;
      repeat (6) @(negedge clk);
      tick = 1'b0;
      rd(A_CNT, v);
      chk("R2 hold while disabled", v, r);
    end

    // R3 free-run rollover
    soft_reset();
    wr(A_CTRL, cw(1, 0, 0, 0, 0, 0, 0));
    tick = 1'b1;
    wait_cnt(255, "R3 reach top");
    rd(A_STAT, r);
    chk("R3 no rollover before wrap", r & 32'h20, 0);
    @(negedge clk);
    rd(A_CNT, r);
    chk("R3 wrap to zero", r, 0);
    rd(A_STAT, r);
    chk("R3 rollover flag", r & 32'h20, 32'h20);
    tick = 1'b0;

    // R4/R5 restart and compare flags
    soft_reset();
    wr(A_CMP1, 6); wr(A_CMP2, 3); wr(A_CMP3, 200);
    wr(A_CTRL, cw(1, 1, 0, 0, 0, 0, 0));
    tick = 1'b1;
    wait_cnt(6, "R4 reach compare 1");
    @(negedge clk);
    rd(A_CNT, r);
    chk("R4 reload after compare 1", r, 0);
    rd(A_STAT, r);
    chk("R5 flags of ch1 ch2 set, ch3 clear", r & 32'h7, 32'h3);
    chk("R3 no rollover in restart loop", r & 32'h20, 0);
    tick = 1'b0;

    // R8 force, R6 pin actions on match
    soft_reset();
    cmpv[0] = 6; cmpv[1] = 3; cmpv[2] = 5;
    wr(A_CMP1, cmpv[0]); wr(A_CMP2, cmpv[1]); wr(A_CMP3, cmpv[2]);
    wr(A_CTRL, cw(0, 0, 0, 0, 2, 0, 0));
    wr(A_CTRL, cw(0, 0, 0, 0, 2, 0, 0) | 32'h8000_0000);
    chk("R8 force drives ch3 low", 32'(cmp_out), 32'h3);
    rd(A_STAT, r);
    chk("R8 force sets no flag", r, 0);
    rd(A_CTRL, r);
    chk("R8 force bit reads zero", r & 32'hE000_0000, 0);
    md[0] = 1; md[1] = 2; md[2] = 3;
    wr(A_CTRL, cw(1, 1, md[0], md[1], md[2], 0, 0));
    ep = 3'b011;
    tick = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      rd(A_CNT, r);
      for (int i = 0; i < 3; i++) begin
        if (r == cmpv[i]) begin
          case (md[i])
            3'd1: ep[i] = ~ep[i];
            3'd2: ep[i] = 1'b0;
            3'd3: ep[i] = 1'b1;
            default: ep[i] = ep[i];
          endcase
        end
      end
      chk("R6 pin actions", 32'(cmp_out), 32'(ep));
    end
    tick = 1'b0;

    // R7 active-low pulse, with and without prescaling
    for (int d = 0; d < 2; d++) begin
      soft_reset();
      wr(A_PRE, 32'(2 * d));
      wr(A_CMP1, 9); wr(A_CMP2, 4);
      wr(A_CTRL, cw(1, 1, 0, 4, 0, 0, 0));
      tick = 1'b1;
      for (int k = 0; k < 45; k++) begin
        @(negedge clk);
        rd(A_CNT, r);
        chk("R7 pulse low for one step", 32'(cmp_out[1]), (r == 4) ? 0 : 1);
      end
      tick = 1'b0;
    end

    // R9/R10 capture
    soft_reset();
    wr(A_CTRL, cw(1, 0, 0, 0, 0, 3, 1));
    tick = 1'b1; repeat (7) @(negedge clk); tick = 1'b0;
    rd(A_CNT, v);
    cap_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(A_STAT, r);
    chk("R10 no flag before sync delay", r & 32'h8, 0);
    @(negedge clk);
    rd(A_STAT, r);
    chk("R10 capture 1 flag", r & 32'h8, 32'h8);
    rd(A_CAP1, r);
    chk("R9 rising capture value", r, v);
    tick = 1'b1; repeat (5) @(negedge clk); tick = 1'b0;
    rd(A_CNT, v2);
    wr(A_STAT, 32'h8);
    cap_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd(A_CAP1, r);
    chk("R9 both-edge falling capture", r, v2);
    rd(A_STAT, r);
    chk("R10 flag after falling edge", r & 32'h8, 32'h8);
    cap_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_CAP2, r);
    chk("R9 channel 2 rising capture", r, v2);
    tick = 1'b1; repeat (3) @(negedge clk); tick = 1'b0;
    wr(A_STAT, 32'h18);
    cap_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(A_CAP2, r);
    chk("R9 rising-only ignores fall", r, v2);
    rd(A_STAT, r);
    chk("R10 no flag for ignored edge", r & 32'h10, 0);
    wr(A_CTRL, cw(1, 0, 0, 0, 0, 0, 1));
    cap_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_CAP1, r);
    chk("R9 disabled channel keeps value", r, v2);
    rd(A_STAT, r);
    chk("R10 disabled channel no flag", r & 32'h8, 0);
    cap_in = 2'b00;

    // R11/R12 clear, collision, interrupt
    soft_reset();
    wr(A_CMP1, 3); wr(A_CMP2, 200); wr(A_CMP3, 200);
    wr(A_IEN, 32'h1);
    wr(A_CTRL, cw(1, 1, 0, 0, 0, 0, 0));
    chk("R12 irq low with no flag", 32'(irq), 0);
    tick = 1'b1;
    wait_cnt(3, "R11 reach match");
    rd(A_STAT, r);
    chk("R5 flag on match", r & 32'h1, 1);
    chk("R12 irq on enabled flag", 32'(irq), 1);
    wait_cnt(0, "R11 reach zero");
    wr(A_STAT, 32'h1);
    rd(A_STAT, r);
    chk("R11 write one clears", r & 32'h1, 0);
    chk("R12 irq drops after clear", 32'(irq), 0);
    @(negedge clk);
    wr(A_STAT, 32'h1);
    rd(A_STAT, r);
    chk("R11 event wins over clear", r & 32'h1, 1);
    wr(A_IEN, 32'h0);
    chk("R12 masked flag gives no irq", 32'(irq), 0);
    tick = 1'b0;

    // R13 software reset
    wr(A_PRE, 5); wr(A_IEN, 32'h3F); wr(A_CMP2, 77);
    wr(A_CTRL, 32'h0000_8000);
    rd(A_CTRL, r);
    chk("R13 reset bit visible one cycle", r, 32'h8000);
    @(negedge clk);
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), r);
      chk("R13 registers cleared", r, 0);
    end
    chk("R13 pins idle", 32'(cmp_out), 32'h7);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule